// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for one display pipe. A pixel counter and a line counter sweep the frame. From them the block derives horizontal and vertical sync, a blanking flag, an active-video flag and a one-cycle pulse at the start of vertical blanking. It also presents the current pixel coordinates so that downstream logic can fetch or generate pixel data. Only progressive scan exists.

Software programs the frame through a small write/read register bus. There are six timing registers, a source-size word and a control word. Every limit is stored as its value minus one. End values sit in bits 31:16 and start values sit in bits 15:0. Writes land in shadow copies.

While the pipe runs, the shadow copies move to the working set only as the counters step onto the first pixel of vertical blanking. A new mode therefore never tears a frame. While the pipe is stopped, the working set follows the shadow copies on every cycle, so the pipe starts with whatever was last written.

Top module: `disp_timing_gen`

## Requirements
- R1: Register addresses are 1 horizontal total/active, 2 horizontal blank end/start, 3 horizontal sync end/start, 4 vertical total/active, 5 vertical blank end/start, 6 vertical sync end/start, 7 source size (width-1 in 31:16, height-1 in 15:0). A read of addresses 1 to 7 returns the last value written, in the cycle after the write, whether or not that value has taken effect yet.
- R2: Address 0 is control. Bit 31 is pipe enable and reads back as written. Bits 23:21 are the scan-mode field and always read 0 (progressive). Every other control bit reads 0.
- R3: While enable is 0, `pix_x` and `pix_y` are 0 from the second cycle after the disabling write, and `active_o`, `hsync_o`, `vsync_o`, `blank_o` and `vblank_start_o` are all 0.
- R4: While enabled, `pix_x` counts up by one per cycle from 0 to the horizontal total field (address 1, bits 31:16) and then wraps to 0. On each wrap, `pix_y` counts up by one and wraps to 0 after reaching the vertical total field (address 4, bits 31:16). The cycle after the enabling write shows position (0,0).
- R5: `active_o` is 1 exactly when `pix_x` <= address 1 bits 15:0 and `pix_y` <= address 4 bits 15:0.
- R6: `hsync_o` is 1 exactly when address 3 bits 15:0 <= `pix_x` <= address 3 bits 31:16. `vsync_o` is 1 exactly when address 6 bits 15:0 <= `pix_y` <= address 6 bits 31:16.
- R7: `blank_o` is 1 when `pix_x` is above address 2 bits 15:0 and at most address 2 bits 31:16, or when `pix_y` is above address 5 bits 15:0 and at most address 5 bits 31:16.
- R8: While enabled, written timing values take effect on the clock edge where the counters leave the last pixel of line number (address 5 bits 15:0). While disabled, they take effect one cycle after the write.
- R9: `vblank_start_o` is high for exactly the one cycle in which the position is pixel 0 of the line after line (address 5 bits 15:0), and for no other cycle.
- R10: `src_size_o` shows the working copy of address 7 and is updated under the same rule as R8.
- R11: After reset, every register reads 0, the pipe is disabled and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pix_x | output | 16 | Current pixel within the line |
| pix_y | output | 16 | Current line within the frame |
| active_o | output | 1 | Position lies in the visible area |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| blank_o | output | 1 | Horizontal or vertical blanking |
| vblank_start_o | output | 1 | One-cycle pulse on the first pixel of vertical blanking |
| src_size_o | output | 32 | Working copy of the source-size word |

## Verification
Register writes are sampled on one rising edge. Read-back is combinational, so a read is checked on the falling edge after that write edge.

Position, sync, active and blank are all decoded without registers from the counters. The counters start moving one edge after the enabling write and fall to zero one edge after the disabling write. The bench's reference state steps on the same rising edges, and every output is compared with it on the following falling edge.

The vertical-blank pulse is registered on the same edge that loads the working set, so it is expected in the first cycle of the new blanking line. The directed tests check it there: they measure line length and pulse spacing in whole cycles from that pulse, and they check the held old timing between a mid-frame write and the next pulse.

// File: rtl/tg_pkg.sv
// Package: shared constants and types for the display timing generator.
// Assumes a 32-bit register word split into two 16-bit half-word fields.
package tg_pkg;
    localparam int HALF_W   = 16;
    localparam int WORD_W   = 2 * HALF_W;
    localparam int ADDR_W   = 3;
    localparam int NUM_REGS = 1 << ADDR_W;
    localparam int NUM_TIME = NUM_REGS - 1;
    localparam int EN_BIT   = WORD_W - 1;

    localparam logic [ADDR_W-1:0] RA_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] RA_HTOT  = 3'd1;
    localparam logic [ADDR_W-1:0] RA_HBLK  = 3'd2;
    localparam logic [ADDR_W-1:0] RA_HSYN  = 3'd3;
    localparam logic [ADDR_W-1:0] RA_VTOT  = 3'd4;
    localparam logic [ADDR_W-1:0] RA_VBLK  = 3'd5;
    localparam logic [ADDR_W-1:0] RA_VSYN  = 3'd6;
    localparam logic [ADDR_W-1:0] RA_SRC   = 3'd7;

    // End (or total) value in the upper field, start (or active) in the lower.
    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } pair_t;

    // One slot per non-control address; slot k holds address k+1.
    typedef pair_t [NUM_TIME-1:0] tset_t;
endpackage

// File: rtl/tg_regs.sv
// Module: register file with shadow and working copies.
// Writes land in shadow slots; the working set loads all slots at once
// when upd_i is high. Control holds only the enable bit; the scan-mode
// field reads as progressive (zero).
module tg_regs
    import tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              upd_i,
    output logic              en_o,
    output tset_t             work_o
);
    logic  en_q;
    tset_t shad_q;
    tset_t work_q;

    // Enable bit of the control word; takes effect at once.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (wr_en && wr_addr == RA_CTRL)
            en_q <= wr_data[EN_BIT];
    end

    // One shadow slot per timing address.
    for (genvar i = 0; i < NUM_TIME; i++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (!rst_n)
                shad_q[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i + 1))
                shad_q[i] <= wr_data;
        end
    end

    // Working set copies the whole shadow set on an update request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            work_q <= '0;
        else if (upd_i)
            work_q <= shad_q;
    end

    // Read mux: control shows enable only, timing slots show shadows.
    always_comb begin
        if (rd_addr == RA_CTRL)
            rd_data = {en_q, {(WORD_W-1){1'b0}}};
        else
            rd_data = shad_q[rd_addr - 3'd1];
    end

    assign en_o   = en_q;
    assign work_o = work_q;
endmodule

// File: rtl/tg_counters.sv
// Module: pixel and line counters with vertical-blank update point.
// Assumes limits are minus-one values. Counters stay at zero while
// disabled; upd_o requests a working-set load while disabled or on the
// edge leaving the last pixel of the final active line.
module tg_counters
    import tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [HALF_W-1:0] htot_i,
    input  logic [HALF_W-1:0] vtot_i,
    input  logic [HALF_W-1:0] vbs_i,
    output logic [HALF_W-1:0] x_o,
    output logic [HALF_W-1:0] y_o,
    output logic              upd_o,
    output logic              pulse_o
);
    logic [HALF_W-1:0] x_q;
    logic [HALF_W-1:0] y_q;
    logic              pulse_q;
    logic              line_end;
    logic              blank_edge;

    assign line_end   = (x_q == htot_i);
    assign blank_edge = line_end && (y_q == vbs_i);
    assign upd_o      = !en_i || blank_edge;

    // Pixel counter: wraps after the horizontal total.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i)
            x_q <= '0;
        else
            x_q <= line_end ? '0 : x_q + 16'd1;
    end

    // Line counter: steps on each line wrap, wraps after the vertical total.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i)
            y_q <= '0;
        else if (line_end)
            y_q <= (y_q == vtot_i) ? '0 : y_q + 16'd1;
    end

    // Pulse marks the first pixel of vertical blanking.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= 1'b0;
        else
            pulse_q <= en_i && blank_edge;
    end

    assign x_o     = x_q;
    assign y_o     = y_q;
    assign pulse_o = pulse_q;

    AST_X_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> x_q <= htot_i); // R4
    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && x_q != htot_i) |=> x_q == $past(x_q) + 16'd1); // R4
    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (x_q == '0 && y_q == '0)); // R3
    AST_PULSE_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> x_q == '0); // R9
endmodule

// File: rtl/tg_decode.sv
// Module: combinational decode of active, sync and blank flags.
// Assumes inclusive minus-one limits from the working set; all flags
// are forced low while the pipe is disabled.
module tg_decode
    import tg_pkg::*;
(
    input  logic              en_i,
    input  logic [HALF_W-1:0] x_i,
    input  logic [HALF_W-1:0] y_i,
    input  tset_t             work_i,
    output logic              active_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              blank_o
);
    pair_t htot, hblk, hsyn, vtot, vblk, vsyn;
    logic  hblank, vblank;

    assign htot = work_i[RA_HTOT - 3'd1];
    assign hblk = work_i[RA_HBLK - 3'd1];
    assign hsyn = work_i[RA_HSYN - 3'd1];
    assign vtot = work_i[RA_VTOT - 3'd1];
    assign vblk = work_i[RA_VBLK - 3'd1];
    assign vsyn = work_i[RA_VSYN - 3'd1];

    // Blank windows open after the start value and close at the end value.
    always_comb begin
        hblank = (x_i > hblk.lo) && (x_i <= hblk.hi);
        vblank = (y_i > vblk.lo) && (y_i <= vblk.hi);
    end

    // Output flags, gated by enable.
    always_comb begin
        active_o = en_i && (x_i <= htot.lo) && (y_i <= vtot.lo);
        hsync_o  = en_i && (x_i >= hsyn.lo) && (x_i <= hsyn.hi);
        vsync_o  = en_i && (y_i >= vsyn.lo) && (y_i <= vsyn.hi);
        blank_o  = en_i && (hblank || vblank);
    end
endmodule

// File: rtl/disp_timing_gen.sv
// Module: top of the display timing generator for one pipe.
// Connects the register file, counters and decode. Progressive scan only.
module disp_timing_gen
    import tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic [15:0]       pix_x,
    output logic [15:0]       pix_y,
    output logic              active_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              blank_o,
    output logic              vblank_start_o,
    output logic [31:0]       src_size_o
);
    logic  en;
    logic  upd;
    tset_t work;
    pair_t htot, vtot, vblk;

    assign htot = work[RA_HTOT - 3'd1];
    assign vtot = work[RA_VTOT - 3'd1];
    assign vblk = work[RA_VBLK - 3'd1];

    tg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .upd_i   (upd),
        .en_o    (en),
        .work_o  (work)
    );

    tg_counters u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en),
        .htot_i  (htot.hi),
        .vtot_i  (vtot.hi),
        .vbs_i   (vblk.lo),
        .x_o     (pix_x),
        .y_o     (pix_y),
        .upd_o   (upd),
        .pulse_o (vblank_start_o)
    );

    tg_decode u_dec (
        .en_i     (en),
        .x_i      (pix_x),
        .y_i      (pix_y),
        .work_i   (work),
        .active_o (active_o),
        .hsync_o  (hsync_o),
        .vsync_o  (vsync_o),
        .blank_o  (blank_o)
    );

    assign src_size_o = work[RA_SRC - 3'd1];
endmodule

// File: tb/disp_timing_gen_bench.sv
module disp_timing_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] pix_x, pix_y;
    logic        active_o, hsync_o, vsync_o, blank_o, vblank_start_o;
    logic [31:0] src_size_o;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    disp_timing_gen u_disp_timing_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pix_x(pix_x), .pix_y(pix_y), .active_o(active_o),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o),
        .vblank_start_o(vblank_start_o), .src_size_o(src_size_o)
    );

    // Reference state built from the requirements
    logic [31:0] m_sh [1:7];
    logic [31:0] m_w  [1:7];
    logic        m_en;
    logic [15:0] m_x, m_y;
    logic        m_pulse;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i < 8; i++) begin
                m_sh[i] <= '0;
                m_w[i]  <= '0;
            end
            m_en <= 1'b0; m_x <= '0; m_y <= '0; m_pulse <= 1'b0;
        end else begin
            if (wr_en) begin
                if (wr_addr == 3'd0) m_en <= wr_data[31];
                else m_sh[wr_addr] <= wr_data;
            end
            if (!m_en || (m_x == m_w[1][31:16] && m_y == m_w[5][15:0]))
                for (int i = 1; i < 8; i++) m_w[i] <= m_sh[i];
            m_pulse <= m_en && m_x == m_w[1][31:16] && m_y == m_w[5][15:0];
            if (!m_en) begin
                m_x <= '0; m_y <= '0;
            end else if (m_x == m_w[1][31:16]) begin
                m_x <= '0;
                m_y <= (m_y == m_w[4][31:16]) ? 16'd0 : m_y + 16'd1;
            end else begin
                m_x <= m_x + 16'd1;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison of every output against the reference
    always @(negedge clk) begin
        if (chk_on && !done) begin
            check("R4", "pix_x", 32'(pix_x), 32'(m_x));
            check("R4", "pix_y", 32'(pix_y), 32'(m_y));
            check("R5", "active", 32'(active_o),
                  32'(m_en && m_x <= m_w[1][15:0] && m_y <= m_w[4][15:0]));
            check("R6", "hsync", 32'(hsync_o),
                  32'(m_en && m_x >= m_w[3][15:0] && m_x <= m_w[3][31:16]));
            check("R6", "vsync", 32'(vsync_o),
                  32'(m_en && m_y >= m_w[6][15:0] && m_y <= m_w[6][31:16]));
            check("R7", "blank", 32'(blank_o),
                  32'(m_en && ((m_x > m_w[2][15:0] && m_x <= m_w[2][31:16]) ||
                               (m_y > m_w[5][15:0] && m_y <= m_w[5][31:16]))));
            check("R9", "vblank_start", 32'(vblank_start_o), 32'(m_pulse));
            check("R10", "src_size", src_size_o, m_w[7]);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [2:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, "rd_data", rd_data, exp);
    endtask

    task automatic wait_pulse();
        for (int n = 0; n < 500; n++) begin
            if (vblank_start_o) return;
            step();
        end
        check("R9", "pulse timeout", 32'd0, 32'd1);
    endtask

    // Table: address, write data, expected read-back
    localparam logic [66:0] VEC [9] = '{
        {3'd0, 32'h00E0_0000, 32'h0000_0000},
        {3'd1, 32'h0009_0005, 32'h0009_0005},
        {3'd2, 32'h0009_0005, 32'h0009_0005},
        {3'd3, 32'h0007_0006, 32'h0007_0006},
        {3'd4, 32'h0005_0003, 32'h0005_0003},
        {3'd5, 32'h0005_0003, 32'h0005_0003},
        {3'd6, 32'h0004_0004, 32'h0004_0004},
        {3'd7, 32'h0005_0003, 32'h0005_0003},
        {3'd0, 32'hFFFF_FFFF, 32'h8000_0000}
    };

    initial begin
        repeat (4) step();
        // R11 / R3: outputs held low under reset
        check("R11", "x in reset", 32'(pix_x), 0);
        check("R11", "flags in reset",
              32'({active_o, hsync_o, vsync_o, blank_o, vblank_start_o}), 0);
        rst_n = 1'b1;
        step();
        rdchk("R11", 3'd0, 32'h0);
        rdchk("R11", 3'd1, 32'h0);
        check("R11", "src after reset", src_size_o, 0);
        chk_on = 1'b1;

        // R1 / R2: table of writes and read-backs
        for (int i = 0; i < 9; i++) begin
            wr(VEC[i][66:64], VEC[i][63:32]);
            rdchk(VEC[i][66:64] == 3'd0 ? "R2" : "R1", VEC[i][66:64], VEC[i][31:0]);
        end

        // R4: first position is (0,0), line length is 10 cycles
        check("R4", "start x", 32'(pix_x), 0);
        check("R4", "start y", 32'(pix_y), 0);
        repeat (10) step();
        check("R4", "x after one line", 32'(pix_x), 0);
        check("R4", "y after one line", 32'(pix_y), 1);

        // R9: pulse at line 4 pixel 0, spacing of one 60-cycle frame
        wait_pulse();
        check("R9", "pulse line", 32'(pix_y), 4);
        begin
            int n = 0;
            step(); n++;
            while (!vblank_start_o && n < 500) begin step(); n++; end
            check("R9", "pulse spacing", n, 60);
        end

        // R8 / R10: mid-frame changes wait for vertical blanking
        step(); step();
        wr(3'd1, 32'h0007_0005);
        rdchk("R1", 3'd1, 32'h0007_0005);
        wr(3'd7, 32'h0001_0002);
        step();
        check("R10", "src held", src_size_o, 32'h0005_0003);
        begin
            bit saw9 = 1'b0;
            for (int n = 0; n < 200 && !vblank_start_o; n++) begin
                if (pix_x == 16'd9) saw9 = 1'b1;
                step();
            end
            check("R8", "old total kept", 32'(saw9), 1);
        end
        check("R10", "src updated", src_size_o, 32'h0001_0002);
        begin
            int n = 0;
            step(); n++;
            while (pix_x != 16'd0 && n < 50) begin step(); n++; end
            check("R8", "new line length", n, 8);
        end

        // R3: disable holds counters at zero and flags low
        wr(3'd0, 32'h0);
        step();
        check("R3", "x disabled", 32'(pix_x), 0);
        check("R3", "y disabled", 32'(pix_y), 0);
        check("R3", "flags disabled",
              32'({active_o, hsync_o, vsync_o, blank_o, vblank_start_o}), 0);
        rdchk("R2", 3'd0, 32'h0);

        // R8: while disabled, new values take effect next cycle
        wr(3'd7, 32'h0003_0004);
        step();
        check("R8", "disabled load", src_size_o, 32'h0003_0004);
        wr(3'd1, 32'h0009_0005);
        wr(3'd0, 32'h8000_0000);
        repeat (130) step();

        chk_on = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule